// File: doc/BRIEF.md
# Double-Edge Serial Capture Slice with Clock-Crossing Word FIFO

This block receives one serial data lane, samples it on both the rising and the falling edge of a fast bit clock, and assembles consecutive samples into parallel words of 4 or 8 bits. Each finished word is written into a small asynchronous FIFO. The FIFO is drained from a slower core clock through a read enable, and an empty flag tells the core when a word is ready.

The ratio is a parameter. Because two bits arrive per bit-clock period, the bit clock runs at 4 times the read clock in 8:1 mode and at 2 times the read clock in 4:1 mode. The block generates no clocks. Both clocks are primary inputs, and their rates must be tied together by the system. Word alignment is fixed by reset: the first sample after reset starts word zero. Delay taps, strobe gating and alignment training are not part of this block.

Top module: `dsr_capture_slice`

## Requirements
- R1: `RATIO` is 4 or 8, and `q_o` is `RATIO` bits wide. Each word holds `RATIO` consecutive serial samples. One sample is taken on each edge of `clk_bit`, and the rising-edge sample of a period comes before its falling-edge sample.
- R2: Sample 0 of the stream is the one taken at the first rising edge of `clk_bit` on which `rst` is sampled low. Words then tile the stream back to back, with no gaps or overlaps.
- R3: Within a word, the earliest sample is in `q_o[0]`. Later samples fill higher indices in order.
- R4: While `rst` is high and after it is released, `empty_o` is 1 and `q_o` is 0 until the first word has crossed to the read side.
- R5: Words come out in the order they were captured. On a rising `clk_rd` edge where `rd_en_i` is 1 and `empty_o` is 0, `q_o` takes the oldest stored word.
- R6: On a rising `clk_rd` edge where `rd_en_i` is 1 and `empty_o` is 1, nothing changes: `q_o` keeps its value, `empty_o` stays 1, and the next word returned is the next one captured.
- R7: When the FIFO already holds `FIFO_DEPTH` unread words, newly finished words are discarded. The stored words are kept and are read out intact.
- R8: `clk_bit` may be stopped and restarted. Capture resumes at the exact sample position where it stopped.
- R9: Each FIFO position counter crossing between the domains changes by at most one bit per clock of its own domain.
- R10: At most one word is written per `RATIO/2` periods of `clk_bit`, and two writes never fall on adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Fast bit clock; data is sampled on both edges |
| clk_rd | input | 1 | Slow core clock for the read side |
| rst | input | 1 | Synchronous active-high reset; must be held high across several edges of both clocks |
| sdata_i | input | 1 | Serial data lane |
| rd_en_i | input | 1 | Read request in the `clk_rd` domain |
| q_o | output | RATIO | Registered parallel word, earliest sample in bit 0 |
| empty_o | output | 1 | Registered flag: no unread word is stored |

## Verification
A wrong alignment counter or a swapped edge shows up at the first word read after reset, as a byte that is rotated or bit-swapped against the expected value. The bench uses a pattern whose values are all distinct modulo 256, so any lost, repeated or reordered word is caught on the very next read. A faulty full or empty comparison shows up in two places. During a deliberate overflow it appears as a wrong word, or as a missing skip, at the ninth read after reading resumes. While the bit clock is stopped, it appears as `empty_o` dropping or `q_o` moving under forced reads.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  // Two samples gathered in one bit-clock period: early = rising edge, late = falling edge.
  typedef struct packed {
    logic late;
    logic early;
  } bit_pair_t;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/dsr_ddr_sampler.sv
module dsr_ddr_sampler
  import dsr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      din,
  output bit_pair_t pair_o,
  output logic      pair_vld_o
);
  logic rise_q;
  logic fall_q;
  logic primed;

  // falling-edge sample of the current period
  always_ff @(negedge clk) begin
    if (rst) fall_q <= 1'b0;
    else     fall_q <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q     <= 1'b0;
      primed     <= 1'b0;
      pair_o     <= '0;
      pair_vld_o <= 1'b0;
    end else begin
      rise_q       <= din;
      primed       <= 1'b1;
      pair_o.early <= rise_q;
      pair_o.late  <= fall_q;
      pair_vld_o   <= primed;
    end
  end
endmodule

// File: rtl/dsr_word_packer.sv
module dsr_word_packer
  import dsr_pkg::*;
#(
  parameter int RATIO = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  bit_pair_t        pair_i,
  input  logic             pair_vld_i,
  output logic [RATIO-1:0] word_o,
  output logic             word_vld_o
);
  localparam int PAIRS = RATIO / 2;
  localparam int CW    = (PAIRS > 1) ? $clog2(PAIRS) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      word_vld_o <= 1'b0;
      if (pair_vld_i) begin
        // new pair enters at the top; after PAIRS shifts the first sample sits in bit 0
        word_o <= {pair_i.late, pair_i.early, word_o[RATIO-1:2]};
        if (cnt == CW'(PAIRS - 1)) begin
          cnt        <= '0;
          word_vld_o <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R10
  word_gap_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld_o |=> !word_vld_o);
endmodule

// File: rtl/dsr_gray_sync.sv
module dsr_gray_sync
  import dsr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[SYNC_STAGES-1];
endmodule

// File: rtl/dsr_cdc_fifo.sv
module dsr_cdc_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [WIDTH-1:0] mem [DEPTH];

  // write side
  logic [PW-1:0] wbin, wgray, rgray_w;
  logic [PW-1:0] wbin_nx, wgray_nx;
  logic          full_r;
  logic          wr_ok;

  assign wr_ok    = wr_en_i & ~full_r;
  assign wbin_nx  = wbin + PW'(wr_ok);
  assign wgray_nx = bin2gray(wbin_nx);

  always_ff @(posedge wclk) begin
    if (rst) begin
      wbin   <= '0;
      wgray  <= '0;
      full_r <= 1'b0;
    end else begin
      wbin   <= wbin_nx;
      wgray  <= wgray_nx;
      full_r <= (wgray_nx == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_ok) mem[wbin[AW-1:0]] <= wdata_i;
  end

  // read side
  logic [PW-1:0] rbin, rgray, wgray_r;
  logic [PW-1:0] rbin_nx;
  logic          rd_ok;

  assign rd_ok   = rd_en_i & ~empty_o;
  assign rbin_nx = rbin + PW'(rd_ok);

  always_ff @(posedge rclk) begin
    if (rst) begin
      rbin    <= '0;
      rgray   <= '0;
      empty_o <= 1'b1;
      rdata_o <= '0;
    end else begin
      rbin    <= rbin_nx;
      rgray   <= bin2gray(rbin_nx);
      empty_o <= (bin2gray(rbin_nx) == wgray_r);
      if (rd_ok) rdata_o <= mem[rbin[AW-1:0]];
    end
  end

  dsr_gray_sync #(.W(PW)) u_sync_r2w (
    .clk (wclk),
    .rst (rst),
    .d_i (rgray),
    .q_o (rgray_w)
  );

  dsr_gray_sync #(.W(PW)) u_sync_w2r (
    .clk (rclk),
    .rst (rst),
    .d_i (wgray),
    .q_o (wgray_r)
  );

  // R9
  wgray_step_chk: assert property (@(posedge wclk) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1);

  // R9
  rgray_step_chk: assert property (@(posedge rclk) disable iff (rst)
    $countones(rgray ^ $past(rgray)) <= 1);

  // R6
  empty_read_chk: assert property (@(posedge rclk) disable iff (rst)
    (rd_en_i && empty_o) |=> ($stable(rdata_o) && $stable(rbin)));

  // R7
  full_drop_chk: assert property (@(posedge wclk) disable iff (rst)
    (wr_en_i && full_r) |=> $stable(wbin));
endmodule

// File: rtl/dsr_capture_slice.sv
module dsr_capture_slice
  import dsr_pkg::*;
#(
  parameter int RATIO      = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic             clk_bit,
  input  logic             clk_rd,
  input  logic             rst,
  input  logic             sdata_i,
  input  logic             rd_en_i,
  output logic [RATIO-1:0] q_o,
  output logic             empty_o
);
  bit_pair_t        pair;
  logic             pair_vld;
  logic [RATIO-1:0] word;
  logic             word_vld;

  dsr_ddr_sampler u_sampler (
    .clk        (clk_bit),
    .rst        (rst),
    .din        (sdata_i),
    .pair_o     (pair),
    .pair_vld_o (pair_vld)
  );

  dsr_word_packer #(.RATIO(RATIO)) u_packer (
    .clk        (clk_bit),
    .rst        (rst),
    .pair_i     (pair),
    .pair_vld_i (pair_vld),
    .word_o     (word),
    .word_vld_o (word_vld)
  );

  dsr_cdc_fifo #(.WIDTH(RATIO), .DEPTH(FIFO_DEPTH)) u_fifo (
    .wclk    (clk_bit),
    .rclk    (clk_rd),
    .rst     (rst),
    .wr_en_i (word_vld),
    .wdata_i (word),
    .rd_en_i (rd_en_i),
    .rdata_o (q_o),
    .empty_o (empty_o)
  );
endmodule

// File: tb/dsr_capture_slice_tb.sv
module dsr_capture_slice_tb;
  localparam int CLK_PERIOD = 4;              // bit clock
  localparam int HALF       = CLK_PERIOD / 2;

  logic fclk = 0, rclk8 = 0, rclk4 = 0;
  logic fclk_run = 1;
  logic rst = 1, sdata = 0, rd8 = 0, rd4 = 0;
  logic [7:0] q8;
  logic [3:0] q4;
  logic e8, e4;

  int errors = 0, checks = 0;
  int exp8 = 0, exp4 = 0;
  int m8 = 0;          // 0 normal read, 1 hold, 2 forced read on empty
  int armed_at = -1;
  logic [7:0] last8 = '0;
  bit done = 0;

  dsr_capture_slice #(.RATIO(8), .FIFO_DEPTH(8)) u_dut (
    .clk_bit(fclk), .clk_rd(rclk8), .rst(rst), .sdata_i(sdata),
    .rd_en_i(rd8), .q_o(q8), .empty_o(e8));

  dsr_capture_slice #(.RATIO(4), .FIFO_DEPTH(8)) u_dut4 (
    .clk_bit(fclk), .clk_rd(rclk4), .rst(rst), .sdata_i(sdata),
    .rd_en_i(rd4), .q_o(q4), .empty_o(e4));

  function automatic logic [7:0] fval(int g);
    return 8'(37 * g + 5);
  endfunction

  function automatic int finv(logic [7:0] v);
    return ((int'(v) + 251) * 173) % 256;
  endfunction

  function automatic logic [3:0] nib(int n);
    logic [7:0] b;
    b = fval(n / 2);
    return (n % 2 == 1) ? b[7:4] : b[3:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial forever begin #HALF; if (fclk_run) fclk = ~fclk; end
  initial begin #3; forever #(CLK_PERIOD * 2) rclk8 = ~rclk8; end
  initial begin #1; forever #(CLK_PERIOD) rclk4 = ~rclk4; end

  // serial driver: rising-edge sample first, falling-edge sample second
  initial begin
    repeat (24) @(posedge fclk);
    // R4 reset state
    chk(e8 == 1'b1, "R4 empty8 in reset", e8, 1);
    chk(q8 == 8'h00, "R4 q8 in reset", q8, 0);
    chk(e4 == 1'b1, "R4 empty4 in reset", e4, 1);
    chk(q4 == 4'h0, "R4 q4 in reset", q4, 0);
    @(negedge fclk); #1;
    rst = 1'b0;
    for (int g = 0; ; g++) begin
      logic [7:0] v;
      v = fval(g);
      for (int b = 0; b < 8; b += 2) begin
        sdata = v[b];
        @(posedge fclk); #1;
        sdata = v[b+1];
        @(negedge fclk); #1;
      end
    end
  end

  // 4:1 reader, always draining
  initial begin
    bit pend4;
    pend4 = 0;
    wait (!rst);
    @(posedge rclk4); #1;
    chk(e4 == 1'b1, "R4 empty4 after release", e4, 1);
    forever begin
      @(negedge rclk4);
      if (pend4) begin
        chk(q4 == nib(exp4), "R1/R2/R3/R5 nibble", q4, nib(exp4));
        exp4++;
      end
      pend4 = !e4;
      rd4   = pend4;
    end
  end

  // 8:1 reader
  initial begin
    bit pend8;
    pend8 = 0;
    wait (!rst);
    @(posedge rclk8); #1;
    chk(e8 == 1'b1, "R4 empty8 after release", e8, 1);
    forever begin
      @(negedge rclk8);
      if (pend8) begin
        if (exp8 == armed_at) begin
          int d;
          d = (finv(q8) - (exp8 % 256) + 256) % 256;
          chk(d > 0, "R7 words after full were dropped", d, 1);
          exp8 = exp8 + d + 1;
          armed_at = -1;
        end else begin
          chk(q8 == fval(exp8), "R1/R2/R3/R5/R7/R8/R9/R10 word", q8, fval(exp8));
          exp8++;
        end
        last8 = q8;
      end
      if (m8 == 2) begin
        chk(e8 == 1'b1, "R6 empty stays set", e8, 1);
        chk(q8 == last8, "R6 q unchanged", q8, last8);
      end
      pend8 = (m8 == 0) && !e8;
      rd8   = (m8 == 2) ? 1'b1 : pend8;
    end
  end

  // test sequence
  initial begin
    int base;
    wait (!rst);
    repeat (40) @(posedge rclk8);
    // overflow: stop reading long enough to fill and drop
    #1 m8 = 1;
    repeat (40) @(posedge rclk8);
    #1;
    base = exp8;
    armed_at = base + 8;
    m8 = 0;
    repeat (40) @(posedge rclk8);
    chk(armed_at == -1, "R7 skip observed", armed_at, -1);
    chk(exp8 > base + 9, "R7 reading resumed", exp8, base + 10);
    // stop the bit clock, drain, then read while empty
    @(negedge fclk); #1 fclk_run = 0;
    repeat (12) @(posedge rclk8);
    #1 m8 = 2;
    repeat (6) @(posedge rclk8);
    #1 m8 = 0;
    repeat (2) @(posedge rclk8);
    fclk_run = 1;
    repeat (40) @(posedge rclk8);
    chk(exp4 > 200, "R1 4:1 progress", exp4, 201);
    chk(exp8 > base + 40, "R8 8:1 progress after pause", exp8, base + 41);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule